// File: doc/BRIEF.md
# Nibble Accumulator ALU with Decimal Adjust

This block is the arithmetic core of a nibble-wide controller. It keeps a 4-bit accumulator and a carry flag in registers. Each cycle in which `exec_i` is high, it applies one operation to the accumulator and to the operand on `opnd_i`. The operations are binary add and subtract (register and immediate forms, with and without carry), decimal correction after a BCD add or subtract, the bitwise AND, XOR and OR, a logical right shift, and a load. All results become visible on the cycle after the operation is issued.

The same opcode input also selects branch decisions. These test a single accumulator bit, test whether the accumulator is zero, or test the state of the carry. The decision appears on `take_o` one cycle later, and it leaves the accumulator and the carry untouched. Subtraction treats the carry as "no borrow". The `cy_en_i` input decides whether the operation now issued may write the carry flag. The instruction sequencer uses this to keep a flag across operations whose carry it does not want.

Top module: `nib_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the carry and `take_o` all become 0.
- R2: When `exec_i` is low at an edge, the accumulator and the carry keep their values and `take_o` is 0 after that edge. Opcodes 0 (no operation), 14, 15 and 24 to 31 behave the same way even when `exec_i` is high.
- R3: ADD (code 2) and ADI (code 6) write acc+opnd modulo 16 and set the carry to the fifth bit of the sum. ADC (code 3) also adds the old carry.
- R4: SUB (code 4) and SBI (code 7) write acc-opnd modulo 16, and the carry becomes 1 exactly when acc >= opnd. SBC (code 5) subtracts one more when the old carry is 0, and its carry is 1 when that difference is not negative.
- R5: DAA (code 8): when acc > 9 or the carry is 1, it writes acc+6 modulo 16 and sets the carry. Otherwise both are unchanged.
- R6: DAS (code 9): when the carry is 0 (a borrow), it writes acc-6 modulo 16. Otherwise the accumulator is unchanged. The carry is never altered.
- R7: AND (10), XOR (11) and OR (12) write acc op opnd. LDA (1) writes opnd. None of these four changes the carry.
- R8: SHR (code 13) writes acc shifted right by one with a 0 entering the top bit, and moves the old acc bit 0 into the carry.
- R9: Branch codes 16 to 19 test acc bits 0 to 3 for one. Code 20 tests acc == 0, code 21 tests acc != 0, code 22 tests carry == 1 and code 23 tests carry == 0. `take_o` shows the result on the next cycle, and the accumulator and the carry are unchanged. Every non-branch operation drives `take_o` to 0.
- R10: When `cy_en_i` is low, no operation changes the carry, while the accumulator is still written as R3 to R8 describe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Issue the operation on this edge |
| op_i | input | 5 | Operation code |
| opnd_i | input | 4 | Second operand or immediate value |
| cy_en_i | input | 1 | Allow this operation to write the carry |
| acc_o | output | 4 | Accumulator |
| cy_o | output | 1 | Carry flag |
| take_o | output | 1 | Branch decision of the previous operation |

## Verification
Every operation is applied to all 256 accumulator/operand pairs, both with the carry preset to 0 and with it preset to 1. For the carry-sensitive operations this separates the with-carry forms from the without-carry forms, and it separates the decimal correction on its value trigger from the correction on its carry trigger. The whole sweep then runs a second time with carry writing disabled, which separates an accumulator update from a carry update. Idle cycles and unused opcodes are placed between operations to show that the state is held.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 5'd0,
    OP_LDA = 5'd1,
    OP_ADD = 5'd2,
    OP_ADC = 5'd3,
    OP_SUB = 5'd4,
    OP_SBC = 5'd5,
    OP_ADI = 5'd6,
    OP_SBI = 5'd7,
    OP_DAA = 5'd8,
    OP_DAS = 5'd9,
    OP_AND = 5'd10,
    OP_XOR = 5'd11,
    OP_OR  = 5'd12,
    OP_SHR = 5'd13,
    OP_BB0 = 5'd16,
    OP_BB1 = 5'd17,
    OP_BB2 = 5'd18,
    OP_BB3 = 5'd19,
    OP_BZ  = 5'd20,
    OP_BNZ = 5'd21,
    OP_BCS = 5'd22,
    OP_BCC = 5'd23
  } op_e;
endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith
  import nib_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic          hit,
  output logic          cwr,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam logic [DW-1:0] DEC_MAX  = DW'(9);
  localparam logic [DW-1:0] DEC_CORR = DW'(6);

  logic [DW:0] sum;
  logic        adj;

  always_comb begin
    hit  = 1'b0;
    cwr  = 1'b0;
    res  = a;
    cout = cin;
    sum  = '0;
    adj  = 1'b0;
    case (op)
      OP_ADD, OP_ADI, OP_ADC: begin
        hit = 1'b1;
        cwr = 1'b1;
        sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, (op == OP_ADC) & cin};
        res = sum[DW-1:0];
        cout = sum[DW];
      end
      OP_SUB, OP_SBI, OP_SBC: begin
        hit = 1'b1;
        cwr = 1'b1;
        sum = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, (op == OP_SBC) ? cin : 1'b1};
        res = sum[DW-1:0];
        cout = sum[DW];
      end
      OP_DAA: begin
        hit = 1'b1;
        cwr = 1'b1;
        adj = (a > DEC_MAX) || cin;
        res = adj ? a + DEC_CORR : a;
        cout = adj | cin;
      end
      OP_DAS: begin
        hit = 1'b1;
        res = cin ? a : a - DEC_CORR;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
  import nib_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic          hit,
  output logic          cwr,
  output logic [DW-1:0] res,
  output logic          cout
);
  always_comb begin
    hit  = 1'b1;
    cwr  = 1'b0;
    res  = a;
    cout = cin;
    case (op)
      OP_LDA: res = b;
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      OP_SHR: begin
        res  = {1'b0, a[DW-1:1]};
        cout = a[0];
        cwr  = 1'b1;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/nib_alu_cond.sv
module nib_alu_cond
  import nib_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic          cy,
  output logic          take
);
  localparam int BIT_BASE = 16;

  logic [DW-1:0] bit_take;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam logic [OPW-1:0] CODE = OPW'(BIT_BASE + i);
    assign bit_take[i] = (op == op_e'(CODE)) && a[i];
  end

  always_comb begin
    case (op)
      OP_BZ:   take = (a == '0);
      OP_BNZ:  take = (a != '0);
      OP_BCS:  take = cy;
      OP_BCC:  take = !cy;
      default: take = |bit_take;
    endcase
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_i,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          cy_en_i,
  output logic [DW-1:0] acc_o,
  output logic          cy_o,
  output logic          take_o
);
  op_e           op;
  logic          ar_hit, ar_cwr, ar_cout;
  logic          lg_hit, lg_cwr, lg_cout;
  logic [DW-1:0] ar_res, lg_res;
  logic          br_take;
  logic [DW-1:0] acc_nx;
  logic          cy_nx;

  assign op = op_e'(op_i);

  nib_alu_arith #(.DW(DW)) u_arith (
    .op(op), .a(acc_o), .b(opnd_i), .cin(cy_o),
    .hit(ar_hit), .cwr(ar_cwr), .res(ar_res), .cout(ar_cout)
  );

  nib_alu_logic #(.DW(DW)) u_logic (
    .op(op), .a(acc_o), .b(opnd_i), .cin(cy_o),
    .hit(lg_hit), .cwr(lg_cwr), .res(lg_res), .cout(lg_cout)
  );

  nib_alu_cond #(.DW(DW)) u_cond (
    .op(op), .a(acc_o), .cy(cy_o), .take(br_take)
  );

  always_comb begin
    acc_nx = acc_o;
    cy_nx  = cy_o;
    if (ar_hit) begin
      acc_nx = ar_res;
      if (ar_cwr && cy_en_i) cy_nx = ar_cout;
    end else if (lg_hit) begin
      acc_nx = lg_res;
      if (lg_cwr && cy_en_i) cy_nx = lg_cout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o  <= '0;
      cy_o   <= 1'b0;
      take_o <= 1'b0;
    end else if (exec_i) begin
      acc_o  <= acc_nx;
      cy_o   <= cy_nx;
      take_o <= br_take;
    end else begin
      take_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          exec_i,
  input logic [4:0]    op_i,
  input logic [DW-1:0] opnd_i,
  input logic          cy_en_i,
  input logic [DW-1:0] acc_o,
  input logic          cy_o,
  input logic          take_o
);
  logic is_branch, is_unused, is_keepc;
  assign is_branch = (op_i >= 5'd16) && (op_i <= 5'd23);
  assign is_unused = (op_i == 5'd0) || (op_i == 5'd14) || (op_i == 5'd15) || (op_i >= 5'd24);
  assign is_keepc  = (op_i == 5'd1) || (op_i == 5'd10) || (op_i == 5'd11) || (op_i == 5'd12);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_o == '0) && !cy_o && !take_o);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> $stable(acc_o) && $stable(cy_o) && !take_o);

  a_r2_unused_holds: assert property (@(posedge clk) disable iff (rst)
    exec_i && is_unused |=> $stable(acc_o) && $stable(cy_o) && !take_o);

  a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
    exec_i && cy_en_i && (op_i == 5'd2) |=>
      {cy_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(opnd_i)}));

  a_r7_logic_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    exec_i && is_keepc |=> $stable(cy_o));

  a_r8_shift_carry: assert property (@(posedge clk) disable iff (rst)
    exec_i && cy_en_i && (op_i == 5'd13) |=>
      (cy_o == $past(acc_o[0])) && (acc_o == ($past(acc_o) >> 1)));

  a_r9_branch_keeps_state: assert property (@(posedge clk) disable iff (rst)
    exec_i && is_branch |=> $stable(acc_o) && $stable(cy_o));

  a_r9_take_after_branch: assert property (@(posedge clk) disable iff (rst)
    exec_i && !is_branch |=> !take_o);

  a_r10_carry_locked: assert property (@(posedge clk) disable iff (rst)
    exec_i && !cy_en_i |=> $stable(cy_o));
endmodule

bind nib_alu nib_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .opnd_i(opnd_i),
  .cy_en_i(cy_en_i), .acc_o(acc_o), .cy_o(cy_o), .take_o(take_o)
);

// File: tb/nib_alu_bench.sv
`timescale 1ns/100ps
module nib_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [3:0] opnd_i = '0;
  logic       cy_en_i = 1'b0;
  logic [3:0] acc_o;
  logic       cy_o, take_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    int       req;
    logic [4:0] op;
    logic [3:0] acc;
    logic       cy;
    logic       tk;
  } exp_t;
  exp_t sb[$];

  // model state
  int m_acc = 0;
  int m_cy = 0;

  always #2.5 clk = ~clk;

  nib_alu u_nib_alu (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .opnd_i(opnd_i),
    .cy_en_i(cy_en_i), .acc_o(acc_o), .cy_o(cy_o), .take_o(take_o)
  );

  function automatic int req_of(int op);
    case (op)
      2, 3, 6: return 3;     // R3
      4, 5, 7: return 4;     // R4
      8:       return 5;     // R5
      9:       return 6;     // R6
      1, 10, 11, 12: return 7; // R7
      13:      return 8;     // R8
      16, 17, 18, 19, 20, 21, 22, 23: return 9; // R9
      default: return 2;     // R2
    endcase
  endfunction

  // driver: drive at negedge, update reference model, push expectation after the edge
  task automatic step(input bit ex, input int op, input int b, input bit cen, input int rq);
    int na, nc, d, tk;
    na = m_acc; nc = m_cy; tk = 0;
    if (ex) begin
      case (op)
        1:  na = b;
        2, 6: begin d = m_acc + b; na = d % 16; nc = d / 16; end
        3:  begin d = m_acc + b + m_cy; na = d % 16; nc = d / 16; end
        4, 7: begin d = m_acc - b; na = (d + 16) % 16; nc = (d >= 0); end
        5:  begin d = m_acc - b - (1 - m_cy); na = (d + 32) % 16; nc = (d >= 0); end
        8:  if (m_acc > 9 || m_cy == 1) begin na = (m_acc + 6) % 16; nc = 1; end
        9:  if (m_cy == 0) na = (m_acc + 10) % 16;
        10: na = m_acc & b;
        11: na = m_acc ^ b;
        12: na = m_acc | b;
        13: begin na = m_acc / 2; nc = m_acc % 2; end
        16, 17, 18, 19: tk = (m_acc >> (op - 16)) & 1;
        20: tk = (m_acc == 0);
        21: tk = (m_acc != 0);
        22: tk = (m_cy == 1);
        23: tk = (m_cy == 0);
        default: ;
      endcase
      if (!cen) nc = m_cy; // R10
    end
    @(negedge clk);
    exec_i  = ex;
    op_i    = 5'(op);
    opnd_i  = 4'(b);
    cy_en_i = cen;
    m_acc = na;
    m_cy  = nc;
    @(posedge clk);
    #1;
    sb.push_back('{req: rq, op: 5'(op), acc: 4'(na), cy: nc[0], tk: tk[0]});
  endtask

  // monitor: compare outputs mid-cycle against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (acc_o !== e.acc || cy_o !== e.cy || take_o !== e.tk) begin
          n_fail++;
          $display("FAIL R%0d op=%0d actual acc=%h cy=%b take=%b expected acc=%h cy=%b take=%b",
                   e.req, e.op, acc_o, cy_o, take_o, e.acc, e.cy, e.tk);
        end
      end
    end
  end

  task automatic preset(input int c, input int a);
    // carry preset via ADD (R3), then load (R7)
    if (c == 1) begin
      step(1, 1, 15, 1, 7);
      step(1, 2, 1, 1, 3);
    end else begin
      step(1, 1, 0, 1, 7);
      step(1, 2, 0, 1, 3);
    end
    step(1, 1, a, 1, 7);
  endtask

  initial begin
    int ops[22];
    ops = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 16, 17, 18, 19, 20, 21, 22, 23, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    n_chk++;
    if (acc_o !== 4'h0 || cy_o !== 1'b0 || take_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 actual acc=%h cy=%b take=%b expected acc=0 cy=0 take=0", acc_o, cy_o, take_o);
    end
    // R2: idle cycles and unused codes hold state
    step(1, 1, 9, 1, 7);
    step(1, 2, 9, 1, 3);
    step(0, 2, 5, 1, 2);
    step(0, 13, 5, 1, 2);
    step(1, 22, 0, 1, 9);
    step(0, 22, 0, 1, 2);
    for (int u = 24; u < 32; u++) step(1, u, 7, 1, 2);
    step(1, 14, 3, 1, 2);
    step(1, 15, 3, 1, 2);
    step(1, 0, 3, 1, 2);
    // R3..R9 exhaustive sweep, then again with carry writes disabled (R10)
    for (int cen = 1; cen >= 0; cen--) begin
      for (int k = 0; k < 22; k++) begin
        for (int c = 0; c < 2; c++) begin
          for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
              preset(c, a);
              step(1, ops[k], b, cen[0], cen == 0 ? 10 : req_of(ops[k]));
            end
          end
        end
      end
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the sequence completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule